// File: doc/BRIEF.md
# Data Toggle Sequencing Engine

This block keeps the DATA0/DATA1 sequence bit in step between the two ends of one bulk endpoint. The transmit half owns a single-entry payload buffer and a toggle bit. It tags each outgoing packet with the matching data PID. The buffer stays loaded until a handshake acknowledges the packet. A missing acknowledge, or a timeout reported by the link layer, leaves the packet queued with the same payload and the same PID, so that it is sent again.

The receive half owns an expected toggle bit. It accepts decoded data packets, each with a PID code, the payload and a CRC-valid flag. It decides whether to acknowledge the packet and whether to hand the payload upward. A packet whose toggle does not match the expected value is a retransmission after a lost handshake. The receive half acknowledges it but does not forward it, so the payload reaches the consumer exactly once. Bit coding, CRC generation and token decoding are done elsewhere and arrive here as strobes and flags.

Top module: `seqtog_engine`

## Requirements
- R1: After reset, or in the cycle after `cfg_clear` is high, both toggle bits read DATA0, `tx_pending` is low and `ld_ready` is high; `cfg_clear` takes priority over every other input in that cycle.
- R2: `tx_pid` is 4'b0011 (DATA0) when the transmit toggle is 0 and 4'b1011 (DATA1) when it is 1, so packets that are acknowledged one after another carry alternating PIDs.
- R3: `ld_ready` equals the inverse of `tx_pending`; a load with `ld_ready` high fills the buffer on the next edge, and a load offered while a packet is pending is stalled and leaves `tx_data` unchanged.
- R4: `hs_ack` while a packet is pending clears `tx_pending` and inverts the transmit toggle on the next edge.
- R5: `hs_timeout` without `hs_ack` while a packet is pending keeps `tx_pending`, `tx_data` and `tx_pid` unchanged and raises `tx_resend` for one cycle; when `hs_ack` and `hs_timeout` are both high, the acknowledge wins.
- R6: `hs_ack` or `hs_timeout` while no packet is pending changes neither the toggle nor `tx_pending`, and raises no `tx_resend`.
- R7: A data packet with valid CRC whose PID toggle bit (bit 3) equals the expected toggle produces one cycle of `rx_ack_out` and `rx_deliver` on the next edge, with the payload on `rx_deliver_data`, and inverts `rx_expect_odd`.
- R8: A packet with a failed CRC produces neither `rx_ack_out` nor `rx_deliver` and leaves `rx_expect_odd` unchanged.
- R9: A packet with valid CRC whose toggle differs from the expected one is a retransmission: `rx_ack_out` is raised, `rx_deliver` stays low and `rx_expect_odd` is unchanged.
- R10: A packet whose PID code is neither 4'b0011 nor 4'b1011 is ignored: no acknowledge, no delivery, no change to the expected toggle.
- R11: With the default zero-idle option, `rx_deliver_data` is all zeros in every cycle in which `rx_deliver` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_clear | input | 1 | Configuration event; returns both toggles to DATA0 and drops the pending packet |
| ld_valid | input | 1 | New payload offered to the transmit buffer |
| ld_data | input | DATA_W | Payload offered |
| ld_ready | output | 1 | Buffer free; a load is taken at the next edge |
| tx_data | output | DATA_W | Payload of the pending packet |
| tx_pid | output | 4 | Data PID code of the pending packet |
| tx_pending | output | 1 | A packet is waiting to be sent or acknowledged |
| hs_ack | input | 1 | Acknowledge received for the pending packet |
| hs_timeout | input | 1 | Handshake wait expired |
| tx_resend | output | 1 | One-cycle pulse: pending packet must be sent again |
| rx_valid | input | 1 | Incoming data packet strobe |
| rx_pid | input | 4 | PID code of the incoming packet |
| rx_crc_ok | input | 1 | CRC of the incoming packet checked good |
| rx_data | input | DATA_W | Payload of the incoming packet |
| rx_ack_out | output | 1 | One-cycle pulse: send an acknowledge |
| rx_deliver | output | 1 | One-cycle pulse: payload accepted for the consumer |
| rx_deliver_data | output | DATA_W | Accepted payload |
| rx_expect_odd | output | 1 | Expected toggle of the next new packet |

## Verification
The receive half is swept through every PID code against both values of the expected toggle, with the CRC flag good and bad. This separates new packets, retransmissions, corrupted packets and non-data codes. The transmit half runs through all combinations of load, acknowledge and timeout, with and without a pending packet, and with configuration clears mixed in. This separates the stall, acknowledge, retry and ignored-handshake cases. A linked run connects the transmit outputs to the receive inputs and drops some acknowledges. It shows that a retransmitted payload is acknowledged but not delivered again, and that every payload arrives once and in order.

// File: rtl/seqtog_pkg.sv
package seqtog_pkg;

   localparam logic [3:0] PID_DATA0 = 4'b0011;
   localparam logic [3:0] PID_DATA1 = 4'b1011;

   function automatic logic [3:0] pid_from_toggle(input logic odd);
      return odd ? PID_DATA1 : PID_DATA0;
   endfunction

   function automatic logic is_data_pid(input logic [3:0] code);
      return (code == PID_DATA0) || (code == PID_DATA1);
   endfunction

   function automatic logic toggle_of_pid(input logic [3:0] code);
      return code[3];
   endfunction

endpackage

// File: rtl/seqtog_tx.sv
module seqtog_tx
   import seqtog_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              ld_valid,
   input  logic [DATA_W-1:0] ld_data,
   output logic              ld_ready,
   input  logic              ack,
   input  logic              tmo,
   output logic [DATA_W-1:0] tx_data,
   output logic [3:0]        tx_pid,
   output logic              tx_pending,
   output logic              tx_resend
);

   if (DATA_W < 1) begin : g_width_chk
      $error("seqtog_tx: DATA_W must be at least 1");
   end

   logic              tog_q;
   logic              pend_q;
   logic              res_q;
   logic [DATA_W-1:0] buf_q;

   logic take_load;
   logic take_ack;
   logic take_retry;

   assign take_ack   = pend_q && ack;
   assign take_load  = !pend_q && ld_valid;
   assign take_retry = pend_q && tmo && !ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tog_q  <= 1'b0;
         pend_q <= 1'b0;
         res_q  <= 1'b0;
      end else if (clr) begin
         tog_q  <= 1'b0;
         pend_q <= 1'b0;
         res_q  <= 1'b0;
      end else begin
         res_q <= take_retry;
         if (take_ack) begin
            pend_q <= 1'b0;
            tog_q  <= ~tog_q;
         end else if (take_load) begin
            pend_q <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q <= '0;
      end else if (!clr && take_load) begin
         buf_q <= ld_data;
      end
   end

   assign ld_ready   = !pend_q;
   assign tx_data    = buf_q;
   assign tx_pid     = pid_from_toggle(tog_q);
   assign tx_pending = pend_q;
   assign tx_resend  = res_q;

   // R4
   ack_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && ack && !clr) |=> (!pend_q && (tog_q != $past(tog_q))));

   // R5
   retry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && tmo && !ack && !clr) |=> (pend_q && $stable(buf_q) && $stable(tog_q) && tx_resend));

   // R3
   stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && ld_valid && !ack && !clr) |=> (pend_q && $stable(buf_q)));

   // R6
   idle_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_q && !ld_valid && (ack || tmo) && !clr) |=> (!pend_q && $stable(tog_q) && !tx_resend));

   // R1
   tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!pend_q && !tog_q && !tx_resend));

endmodule

// File: rtl/seqtog_rx.sv
module seqtog_rx
   import seqtog_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter bit ZERO_IDLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              rx_valid,
   input  logic [3:0]        rx_pid,
   input  logic              rx_crc_ok,
   input  logic [DATA_W-1:0] rx_data,
   output logic              rx_ack_out,
   output logic              rx_deliver,
   output logic [DATA_W-1:0] rx_deliver_data,
   output logic              rx_expect_odd
);

   if (DATA_W < 1) begin : g_width_chk
      $error("seqtog_rx: DATA_W must be at least 1");
   end

   logic              exp_q;
   logic              ack_q;
   logic              del_q;
   logic [DATA_W-1:0] dd_q;

   logic good_pkt;
   logic fresh_pkt;

   assign good_pkt  = rx_valid && rx_crc_ok && is_data_pid(rx_pid);
   assign fresh_pkt = good_pkt && (toggle_of_pid(rx_pid) == exp_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp_q <= 1'b0;
         ack_q <= 1'b0;
         del_q <= 1'b0;
      end else if (clr) begin
         exp_q <= 1'b0;
         ack_q <= 1'b0;
         del_q <= 1'b0;
      end else begin
         ack_q <= good_pkt;
         del_q <= fresh_pkt;
         if (fresh_pkt) begin
            exp_q <= ~exp_q;
         end
      end
   end

   if (ZERO_IDLE) begin : g_zero_idle
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dd_q <= '0;
         end else if (!clr && fresh_pkt) begin
            dd_q <= rx_data;
         end else begin
            dd_q <= '0;
         end
      end

      // R11
      zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !del_q |-> (dd_q == '0));
   end else begin : g_hold_last
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dd_q <= '0;
         end else if (!clr && fresh_pkt) begin
            dd_q <= rx_data;
         end
      end
   end

   assign rx_ack_out      = ack_q;
   assign rx_deliver      = del_q;
   assign rx_deliver_data = dd_q;
   assign rx_expect_odd   = exp_q;

   // R8
   crc_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !rx_crc_ok && !clr) |=> (!ack_q && !del_q && $stable(exp_q)));

   // R9
   dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_crc_ok && is_data_pid(rx_pid) && (rx_pid[3] != exp_q) && !clr)
      |=> (ack_q && !del_q && $stable(exp_q)));

   // R7
   deliver_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      del_q |-> ack_q);

   // R7
   fresh_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_crc_ok && (rx_pid == PID_DATA0 || rx_pid == PID_DATA1) && (rx_pid[3] == exp_q) && !clr)
      |=> (del_q && (exp_q != $past(exp_q))));

   // R10
   nonpid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_pid != PID_DATA0 && rx_pid != PID_DATA1 && !clr)
      |=> (!ack_q && !del_q && $stable(exp_q)));

   // R1
   rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!exp_q && !ack_q && !del_q));

endmodule

// File: rtl/seqtog_engine.sv
module seqtog_engine
   import seqtog_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter bit ZERO_IDLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_clear,
   input  logic              ld_valid,
   input  logic [DATA_W-1:0] ld_data,
   output logic              ld_ready,
   output logic [DATA_W-1:0] tx_data,
   output logic [3:0]        tx_pid,
   output logic              tx_pending,
   input  logic              hs_ack,
   input  logic              hs_timeout,
   output logic              tx_resend,
   input  logic              rx_valid,
   input  logic [3:0]        rx_pid,
   input  logic              rx_crc_ok,
   input  logic [DATA_W-1:0] rx_data,
   output logic              rx_ack_out,
   output logic              rx_deliver,
   output logic [DATA_W-1:0] rx_deliver_data,
   output logic              rx_expect_odd
);

   seqtog_tx #(
      .DATA_W (DATA_W)
   ) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (cfg_clear),
      .ld_valid   (ld_valid),
      .ld_data    (ld_data),
      .ld_ready   (ld_ready),
      .ack        (hs_ack),
      .tmo        (hs_timeout),
      .tx_data    (tx_data),
      .tx_pid     (tx_pid),
      .tx_pending (tx_pending),
      .tx_resend  (tx_resend)
   );

   seqtog_rx #(
      .DATA_W    (DATA_W),
      .ZERO_IDLE (ZERO_IDLE)
   ) u_rx (
      .clk             (clk),
      .rst_n           (rst_n),
      .clr             (cfg_clear),
      .rx_valid        (rx_valid),
      .rx_pid          (rx_pid),
      .rx_crc_ok       (rx_crc_ok),
      .rx_data         (rx_data),
      .rx_ack_out      (rx_ack_out),
      .rx_deliver      (rx_deliver),
      .rx_deliver_data (rx_deliver_data),
      .rx_expect_odd   (rx_expect_odd)
   );

   // R2
   pid_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_pid == PID_DATA0) || (tx_pid == PID_DATA1));

endmodule

// File: tb/seqtog_engine_tb.sv
module seqtog_engine_tb;

   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_clear = 1'b0;
   logic          ld_valid = 1'b0;
   logic [DW-1:0] ld_data = '0;
   logic          ld_ready;
   logic [DW-1:0] tx_data;
   logic [3:0]    tx_pid;
   logic          tx_pending;
   logic          hs_ack = 1'b0;
   logic          hs_timeout = 1'b0;
   logic          tx_resend;
   logic          rx_valid = 1'b0;
   logic [3:0]    rx_pid = '0;
   logic          rx_crc_ok = 1'b0;
   logic [DW-1:0] rx_data = '0;
   logic          rx_ack_out;
   logic          rx_deliver;
   logic [DW-1:0] rx_deliver_data;
   logic          rx_expect_odd;

   int n_chk = 0;
   int n_bad = 0;

   logic          m_tog = 1'b0, m_pend = 1'b0, m_res = 1'b0;
   logic [DW-1:0] m_buf = '0;
   logic          m_exp = 1'b0, e_ack = 1'b0, e_del = 1'b0;
   logic [DW-1:0] e_dd = '0;

   always #10 clk = ~clk;

   seqtog_engine #(.DATA_W(DW), .ZERO_IDLE(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_clear(cfg_clear),
      .ld_valid(ld_valid), .ld_data(ld_data), .ld_ready(ld_ready),
      .tx_data(tx_data), .tx_pid(tx_pid), .tx_pending(tx_pending),
      .hs_ack(hs_ack), .hs_timeout(hs_timeout), .tx_resend(tx_resend),
      .rx_valid(rx_valid), .rx_pid(rx_pid), .rx_crc_ok(rx_crc_ok), .rx_data(rx_data),
      .rx_ack_out(rx_ack_out), .rx_deliver(rx_deliver),
      .rx_deliver_data(rx_deliver_data), .rx_expect_odd(rx_expect_odd)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [3:0] pid_exp(input logic odd);
      return odd ? 4'b1011 : 4'b0011;
   endfunction

   task automatic check_outs();
      chk(tx_pending == m_pend, "R4 pending", 32'(tx_pending), 32'(m_pend));
      chk(tx_pid == pid_exp(m_tog), "R2 pid", 32'(tx_pid), 32'(pid_exp(m_tog)));
      if (m_pend) chk(tx_data == m_buf, "R3 buffer", 32'(tx_data), 32'(m_buf));
      chk(tx_resend == m_res, "R5 resend", 32'(tx_resend), 32'(m_res));
      chk(rx_ack_out == e_ack, "R9 ack", 32'(rx_ack_out), 32'(e_ack));
      chk(rx_deliver == e_del, "R7 deliver", 32'(rx_deliver), 32'(e_del));
      chk(rx_deliver_data == e_dd, "R11 data", 32'(rx_deliver_data), 32'(e_dd));
      chk(rx_expect_odd == m_exp, "R8 expect", 32'(rx_expect_odd), 32'(m_exp));
   endtask

   // one clock: pre-edge check, edge, model update, post-edge check
   task automatic step();
      logic good;
      chk(ld_ready == !m_pend, "R3 ready", 32'(ld_ready), 32'(!m_pend));
      @(posedge clk);
      #5;
      if (cfg_clear) begin
         m_tog = 1'b0; m_pend = 1'b0; m_res = 1'b0;
         m_exp = 1'b0; e_ack = 1'b0; e_del = 1'b0; e_dd = '0;
      end else begin
         m_res = hs_timeout && m_pend && !hs_ack;
         if (m_pend && hs_ack) begin
            m_pend = 1'b0; m_tog = ~m_tog;
         end else if (!m_pend && ld_valid) begin
            m_pend = 1'b1; m_buf = ld_data;
         end
         good  = rx_valid && rx_crc_ok && (rx_pid == 4'b0011 || rx_pid == 4'b1011);
         e_ack = good;
         e_del = good && (rx_pid[3] == m_exp);
         e_dd  = e_del ? rx_data : '0;
         if (e_del) m_exp = ~m_exp;
      end
      check_outs();
   endtask

   task automatic idle_inputs();
      cfg_clear = 0; ld_valid = 0; hs_ack = 0; hs_timeout = 0; rx_valid = 0; rx_crc_ok = 0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      int delivered;
      logic [DW-1:0] want;
      repeat (3) @(posedge clk);
      #5;
      // R1 reset state
      check_outs();
      chk(ld_ready == 1'b1, "R1 ready", 32'(ld_ready), 32'd1);
      rst_n = 1'b1;

      // transmit sweep: all load/ack/timeout combinations, with clears
      for (int i = 0; i < 480; i++) begin
         logic [2:0] op;
         op = 3'(i ^ (i >> 3) ^ (i >> 6));
         idle_inputs();
         ld_valid   = op[0];
         hs_ack     = op[1];
         hs_timeout = op[2];
         ld_data    = 8'(i * 29 + 7);
         cfg_clear  = (i % 61 == 60);
         step();
      end

      // receive sweep: every PID code, CRC good/bad, both expected toggles
      for (int pass = 0; pass < 3; pass++) begin
         for (int k = 0; k < 64; k++) begin
            idle_inputs();
            rx_valid  = (k % 7 != 3);
            rx_pid    = 4'(k);
            rx_crc_ok = k[4] ^ pass[0];
            rx_data   = 8'(k * 13 + pass);
            cfg_clear = (pass == 2 && k == 40);
            step();
         end
      end

      // R1: clear both sides, then linked run with lost acknowledges
      idle_inputs();
      cfg_clear = 1;
      step();
      chk(rx_expect_odd == 1'b0 && tx_pid == 4'b0011, "R1 clear", 32'({rx_expect_odd, tx_pid}), 32'h3);
      delivered = 0;
      for (int p = 0; p < 12; p++) begin
         idle_inputs();
         ld_valid = 1; ld_data = 8'(p * 17 + 1);
         step();
         for (int att = 0; att < 2; att++) begin
            idle_inputs();
            rx_valid = 1; rx_crc_ok = 1; rx_pid = tx_pid; rx_data = tx_data;
            step();
            if (rx_deliver) begin
               want = 8'(delivered * 17 + 1);
               chk(rx_deliver_data == want, "R9 order", 32'(rx_deliver_data), 32'(want));
               delivered++;
            end
            idle_inputs();
            if (att == 0 && (p % 3 == 1)) begin
               hs_timeout = 1;
               step();
               chk(tx_resend == 1'b1, "R5 lost ack", 32'(tx_resend), 32'd1);
            end else begin
               hs_ack = rx_ack_out;
               step();
               break;
            end
         end
      end
      chk(delivered == 12, "R9 once", 32'(delivered), 32'd12);
      idle_inputs();
      step();

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule